// File: doc/BRIEF.md
# Timer Interrupt Flag Unit

This block holds the pending-interrupt flags for two timer/counters in one 8-bit register. Each timer reports compare-match and overflow events as single-cycle strobes. The block latches every strobe into a sticky flag. A flag stays set until software writes a one to its bit, or until the processor takes the matching interrupt vector and pulses an acknowledge line.

Each flag has its own request output. A request is raised only while the flag is set, the flag's own enable is set and the global interrupt enable is set. The timer-1 overflow flag takes its set source from the timer-1 mode. In normal mode it follows the counter overflow. When either PWM enable of timer 1 is on, it follows the match against the third compare register of timer 1.

A write-one clear passes through a one-cycle pipeline register before it acts. An event that arrives in the same cycle as any clear always leaves its flag set, so no event is lost.

Top module: `tmr_irq_flags`

## Requirements
- R1: Source index i (0..5) maps to register bit i+1 for evt_i, ack_i, src_en_i and irq_o. The sources, from index 0 up, are: timer-0 overflow, timer-1 overflow, timer-0 compare B, timer-0 compare A, timer-1 compare B, timer-1 compare A.
- R2: After reset every bit of reg_rdata_o reads 0. Bits 7 and 0 always read 0, and writing ones to them changes nothing.
- R3: A strobe on evt_i[i] for any i other than 1 sets register bit i+1, visible after that clock edge.
- R4: With pwm_a_en_i and pwm_b_en_i both 0, evt_i[1] sets bit 2, and cmp_c_i has no effect.
- R5: With pwm_a_en_i or pwm_b_en_i at 1, cmp_c_i sets bit 2, and evt_i[1] has no effect.
- R6: A pulse on ack_i[i] clears bit i+1 at the same clock edge.
- R7: A write with reg_wdata_i bit i+1 at 1 clears that flag one cycle after the write edge. Until then the flag still reads 1. Bits written as 0 are left unchanged.
- R8: When a set event and a clear (an acknowledge, or a write clear still in the pipeline) reach the same flag in the same cycle, the flag ends up set.
- R9: irq_o[i] is 1 exactly when gie_i, src_en_i[i] and flag bit i+1 are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 6 | Event strobes, per source index |
| cmp_c_i | input | 1 | Timer-1 compare C match strobe |
| pwm_a_en_i | input | 1 | Timer-1 PWM enable A |
| pwm_b_en_i | input | 1 | Timer-1 PWM enable B |
| ack_i | input | 6 | Vector-taken acknowledge, per source |
| src_en_i | input | 6 | Per-source interrupt enable |
| gie_i | input | 1 | Global interrupt enable |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Write data, one means clear |
| reg_rdata_o | output | 8 | Flag register read value |
| irq_o | output | 6 | Per-source interrupt requests |

## Verification
The bench builds the block with its default parameters: an 8-bit register with the six flags at bits 1 to 6. This layout puts both reserved bits inside the write data path, so the bench can write ones to them and confirm nothing changes. The stimulus table steps through both timer-1 modes and both PWM enables. It also covers an event landing while a write clear is still in its pipeline cycle, and an event landing together with an acknowledge. Directed tests then sweep the global enable and the per-source enables against a fixed flag pattern, and apply a reset in the middle of the run.

// File: rtl/tif_pkg.sv
`timescale 1ns/1ps
package tif_pkg;
  // Number of flag sources and their position inside the register
  localparam int SRC_N    = 6;
  localparam int FLAG_LSB = 1;
  // Source indices
  localparam int IDX_OVF0  = 0;
  localparam int IDX_OVF1  = 1;
  localparam int IDX_CMP0B = 2;
  localparam int IDX_CMP0A = 3;
  localparam int IDX_CMP1B = 4;
  localparam int IDX_CMP1A = 5;

  typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/tif_src_select.sv
`timescale 1ns/1ps
module tif_src_select
  import tif_pkg::*;
(
  input  logic     [SRC_N-1:0] evt_i,
  input  logic                 cmp_c_i,
  input  logic                 pwm_a_en_i,
  input  logic                 pwm_b_en_i,
  output logic     [SRC_N-1:0] set_o
);
  logic pwm_mode;

  always_comb begin
    pwm_mode = pwm_a_en_i | pwm_b_en_i;
  end

  genvar g;
  generate
    for (g = 0; g < SRC_N; g++) begin : g_sel
      if (g == IDX_OVF1) begin : g_ovf1
        // timer-1 overflow flag: source depends on mode
        always_comb begin
          set_o[g] = pwm_mode ? cmp_c_i : evt_i[g];
        end
      end else begin : g_plain
        always_comb begin
          set_o[g] = evt_i[g];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/tif_wclr_pipe.sv
`timescale 1ns/1ps
module tif_wclr_pipe
  import tif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [SRC_N-1:0] mask_i,
  output logic [SRC_N-1:0] clr_o
);
  logic [SRC_N-1:0] clr_d;
  logic [SRC_N-1:0] clr_q;
  logic             clr_ce;

  always_comb begin
    clr_d  = wr_i ? mask_i : '0;
    // only load when a new write arrives or a pending clear must retire
    clr_ce = wr_i | (|clr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q <= '0;
    end else if (clr_ce) begin
      clr_q <= clr_d;
    end
  end

  assign clr_o = clr_q;
endmodule

// File: rtl/tif_flag_bit.sv
`timescale 1ns/1ps
module tif_flag_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  input  logic wclr_i,
  output logic q_o
);
  logic q;
  logic d;
  logic ce;

  always_comb begin
    ce = set_i | ack_i | wclr_i;
    // a set always dominates any clear
    d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (ce) begin
      q <= d;
    end
  end

  assign q_o = q;
endmodule

// File: rtl/tif_req_gate.sv
`timescale 1ns/1ps
module tif_req_gate
  import tif_pkg::*;
(
  input  logic             gie_i,
  input  logic [SRC_N-1:0] en_i,
  input  logic [SRC_N-1:0] flag_i,
  output logic [SRC_N-1:0] irq_o
);
  always_comb begin
    irq_o = gie_i ? (en_i & flag_i) : '0;
  end
endmodule

// File: rtl/tmr_irq_flags.sv
`timescale 1ns/1ps
module tmr_irq_flags
  import tif_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       evt_i,
  input  logic             cmp_c_i,
  input  logic             pwm_a_en_i,
  input  logic             pwm_b_en_i,
  input  logic [5:0]       ack_i,
  input  logic [5:0]       src_en_i,
  input  logic             gie_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic [5:0]       irq_o
);
  localparam int FLAG_MSB = FLAG_LSB + SRC_N - 1;

  logic [SRC_N-1:0] set_vec;
  logic [SRC_N-1:0] wclr_vec;
  logic [SRC_N-1:0] flags;
  logic             unused_wbits;

  // reserved write bits are deliberately dropped
  assign unused_wbits = ^{reg_wdata_i[REG_W-1:FLAG_MSB+1], reg_wdata_i[FLAG_LSB-1:0]};

  tif_src_select u_sel (
    .evt_i      (evt_i),
    .cmp_c_i    (cmp_c_i),
    .pwm_a_en_i (pwm_a_en_i),
    .pwm_b_en_i (pwm_b_en_i),
    .set_o      (set_vec)
  );

  tif_wclr_pipe u_wclr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (reg_wr_i),
    .mask_i (reg_wdata_i[FLAG_MSB:FLAG_LSB]),
    .clr_o  (wclr_vec)
  );

  genvar g;
  generate
    for (g = 0; g < SRC_N; g++) begin : g_flag
      tif_flag_bit u_bit (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec[g]),
        .ack_i  (ack_i[g]),
        .wclr_i (wclr_vec[g]),
        .q_o    (flags[g])
      );
    end
  endgenerate

  always_comb begin
    reg_rdata_o                    = '0;
    reg_rdata_o[FLAG_MSB:FLAG_LSB] = flags;
  end

  tif_req_gate u_gate (
    .gie_i  (gie_i),
    .en_i   (src_en_i),
    .flag_i (flags),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/tif_checker.sv
`timescale 1ns/1ps
module tif_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] evt_i,
  input logic       cmp_c_i,
  input logic       pwm_a_en_i,
  input logic       pwm_b_en_i,
  input logic [5:0] ack_i,
  input logic [5:0] src_en_i,
  input logic       gie_i,
  input logic       reg_wr_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic [5:0] irq_o
);
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata_o[7] == 1'b0) && (reg_rdata_o[0] == 1'b0));

  p_cmp_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i[5] |=> reg_rdata_o[6]);

  p_ovf0_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i[0] |=> reg_rdata_o[1]);

  p_norm_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_a_en_i && !pwm_b_en_i && evt_i[1]) |=> reg_rdata_o[2]);

  p_pwm_topc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwm_a_en_i || pwm_b_en_i) && cmp_c_i) |=> reg_rdata_o[2]);

  p_pwm_no_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwm_a_en_i || pwm_b_en_i) && !cmp_c_i && !reg_rdata_o[2]) |=> !reg_rdata_o[2]);

  p_ack_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i[0] && !evt_i[0]) |=> !reg_rdata_o[1]);

  p_wr_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_wr_i && reg_wdata_i[4]) && !evt_i[3]) |=> !reg_rdata_o[4]);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i[3] && evt_i[3]) |=> reg_rdata_o[4]);

  p_irq_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_o) |-> gie_i);

  p_irq_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[2] |-> (src_en_i[2] && reg_rdata_o[3]));
endmodule

bind tmr_irq_flags tif_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_i       (evt_i),
  .cmp_c_i     (cmp_c_i),
  .pwm_a_en_i  (pwm_a_en_i),
  .pwm_b_en_i  (pwm_b_en_i),
  .ack_i       (ack_i),
  .src_en_i    (src_en_i),
  .gie_i       (gie_i),
  .reg_wr_i    (reg_wr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o)
);

// File: tb/tmr_irq_flags_bench.sv
`timescale 1ns/1ps
module tmr_irq_flags_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] evt_i;
  logic       cmp_c_i;
  logic       pwm_a_en_i;
  logic       pwm_b_en_i;
  logic [5:0] ack_i;
  logic [5:0] src_en_i;
  logic       gie_i;
  logic       reg_wr_i;
  logic [7:0] reg_wdata_i;
  logic [7:0] reg_rdata_o;
  logic [5:0] irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tmr_irq_flags u_tmr_irq_flags (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .cmp_c_i(cmp_c_i),
    .pwm_a_en_i(pwm_a_en_i), .pwm_b_en_i(pwm_b_en_i), .ack_i(ack_i),
    .src_en_i(src_en_i), .gie_i(gie_i), .reg_wr_i(reg_wr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [5:0] evt;
    logic       cmpc;
    logic [1:0] pwm;
    logic [5:0] ack;
    logic       wr;
    logic [7:0] wdata;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  // register value expected after the edge that consumes each row
  localparam vec_t TBL [21] = '{
    '{6'b000001, 1'b0, 2'b00, 6'b000000, 1'b0, 8'h00, 8'h02, 4'd3}, // R3 ovf0
    '{6'b111101, 1'b0, 2'b00, 6'b000000, 1'b0, 8'h00, 8'h7A, 4'd1}, // R1 layout
    '{6'b000010, 1'b0, 2'b00, 6'b000000, 1'b0, 8'h00, 8'h7E, 4'd4}, // R4 overflow
    '{6'b000000, 1'b0, 2'b00, 6'b000000, 1'b1, 8'hFF, 8'h7E, 4'd7}, // R7 not yet
    '{6'b000000, 1'b0, 2'b00, 6'b000000, 1'b0, 8'h00, 8'h00, 4'd7}, // R7 cleared
    '{6'b000000, 1'b0, 2'b00, 6'b000000, 1'b0, 8'h00, 8'h00, 4'd2},
    '{6'b000010, 1'b0, 2'b01, 6'b000000, 1'b0, 8'h00, 8'h00, 4'd5}, // R5 ovf ignored
    '{6'b000000, 1'b1, 2'b10, 6'b000000, 1'b0, 8'h00, 8'h04, 4'd5}, // R5 compare C
    '{6'b000000, 1'b0, 2'b00, 6'b000010, 1'b0, 8'h00, 8'h00, 4'd6}, // R6 ack
    '{6'b000000, 1'b1, 2'b00, 6'b000000, 1'b0, 8'h00, 8'h00, 4'd4}, // R4 C ignored
    '{6'b111101, 1'b0, 2'b00, 6'b000000, 1'b0, 8'h00, 8'h7A, 4'd3},
    '{6'b000000, 1'b0, 2'b00, 6'b000000, 1'b1, 8'h81, 8'h7A, 4'd2}, // R2 reserved
    '{6'b000000, 1'b0, 2'b00, 6'b000000, 1'b0, 8'h00, 8'h7A, 4'd2},
    '{6'b000000, 1'b0, 2'b00, 6'b000000, 1'b1, 8'h10, 8'h7A, 4'd7},
    '{6'b001000, 1'b0, 2'b00, 6'b000000, 1'b0, 8'h00, 8'h7A, 4'd8}, // R8 vs write
    '{6'b000000, 1'b0, 2'b00, 6'b000000, 1'b0, 8'h00, 8'h7A, 4'd8},
    '{6'b000001, 1'b0, 2'b00, 6'b000001, 1'b0, 8'h00, 8'h7A, 4'd8}, // R8 vs ack
    '{6'b000000, 1'b0, 2'b00, 6'b111111, 1'b0, 8'h00, 8'h00, 4'd6},
    '{6'b000100, 1'b0, 2'b00, 6'b000000, 1'b0, 8'h00, 8'h08, 4'd3},
    '{6'b000000, 1'b0, 2'b00, 6'b000000, 1'b1, 8'h00, 8'h08, 4'd7}, // R7 zero write
    '{6'b000000, 1'b0, 2'b00, 6'b000000, 1'b0, 8'h00, 8'h08, 4'd7}
  };

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    evt_i = '0; cmp_c_i = 1'b0; pwm_a_en_i = 1'b0; pwm_b_en_i = 1'b0;
    ack_i = '0; reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  initial begin
    rst_n = 1'b0; gie_i = 1'b0; src_en_i = '0;
    idle_inputs();
    repeat (3) @(negedge clk);
    // R2 reset value
    check8("R2 reset", reg_rdata_o, 8'h00);
    check8("R9 reset irq", {2'b00, irq_o}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 21; i++) begin
      evt_i = TBL[i].evt; cmp_c_i = TBL[i].cmpc;
      pwm_a_en_i = TBL[i].pwm[0]; pwm_b_en_i = TBL[i].pwm[1];
      ack_i = TBL[i].ack; reg_wr_i = TBL[i].wr; reg_wdata_i = TBL[i].wdata;
      @(negedge clk);
      check8($sformatf("R%0d row %0d", TBL[i].req, i), reg_rdata_o, TBL[i].exp);
    end
    idle_inputs();
    @(negedge clk);
    // R9 gating, flags hold 0x08 (source index 2)
    gie_i = 1'b0; src_en_i = 6'b111111; #1;
    check8("R9 gie off", {2'b00, irq_o}, 8'h00);
    gie_i = 1'b1; src_en_i = 6'b000000; #1;
    check8("R9 enables off", {2'b00, irq_o}, 8'h00);
    src_en_i = 6'b111111; #1;
    check8("R9 all on", {2'b00, irq_o}, 8'h04);
    src_en_i = 6'b111011; #1;
    check8("R9 own enable off", {2'b00, irq_o}, 8'h00);
    src_en_i = 6'b000100; #1;
    check8("R9 own enable on", {2'b00, irq_o}, 8'h04);
    // R2 reset in mid run
    @(negedge clk);
    rst_n = 1'b0; #1;
    check8("R2 mid-run reset", reg_rdata_o, 8'h00);
    check8("R9 irq after reset", {2'b00, irq_o}, 8'h00);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule